// File: doc/BRIEF.md
# Two-Section Low-Pass Shift-Add IIR Filter

This block is a fixed low-pass IIR filter built from two second-order sections in series. The coefficients are set at elaboration and cannot change at run time. Each coefficient is a short list of signed power-of-two terms. A term is either added or subtracted, so the filter has no general multiplier. A term list entry that is not in use produces no adder at all. The feedback coefficients are applied by subtraction within the same adder chain. The section's scale factor is folded into each term's shift, so no separate scaling shifter exists.

Samples enter on a valid/ready stream and results leave on a second valid/ready stream. Each section is one pipeline stage. A section takes a sample only when its output register is empty, or when that register is being drained in the same cycle. The sections are chained, so back-pressure on the output travels back to the input one stage at a time. A sample offered while `in_ready` is low is not taken. The data must stay on the input until a cycle in which `in_valid` and `in_ready` are both high.

Top module: `lp_sos_cascade`

## Requirements
- R1: During reset and in the first cycle after reset, `out_valid` is low and `in_ready` is high. Both sections start with all past inputs and past outputs at zero.
- R2: Each section computes a 22-bit sum of signed terms. Each term is a past or present value, sign-extended and shifted left by the term's shift, and it carries the weight ±2^shift/256. The b-coefficient products are added. The a-coefficient products (on the two past outputs) are subtracted. The section output is bits [21:8] of the sum.
- R3: The 14-bit output of the first section is the input of the second section. `out_data` is the output of the second section.
- R4: If the output is not stalled, `out_valid` rises on the second clock edge after the edge that accepts a sample. It is still low after the first of these edges.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R6: If both sections hold a sample and `out_ready` is low, then `in_ready` is low. A value presented on `in_data` in such a cycle is not taken into the filter.
- R7: The section state advances only on accepted samples. Idle cycles between samples leave every later result unchanged.
- R8: Each accepted sample produces exactly one output. Outputs come out in input order.
- R9: The 22-bit sums wrap modulo 2^22 and the 14-bit outputs are the plain bit slice, with no saturation.
- R10: The default coefficients, in units of 1/256, are as follows. Section one: b = 8, 16, 8 and a1 = −384, a2 = 160. Section two: b = 16, 32, 16 and a1 = −320, a2 = 128. Each section has unit gain at DC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Filter can take a sample this cycle |
| in_data | input | 14 | Signed input sample |
| out_valid | output | 1 | Filtered sample available |
| out_ready | input | 1 | Downstream takes the output this cycle |
| out_data | output | 14 | Signed filtered sample |

## Verification
The bench uses the default parameters: 14-bit samples, 22-bit sums, two term slots per coefficient, and the R10 coefficients. These include subtracted terms, unused term slots, shifts up to 8 and feedback gains above one, so every branch of the shift-add generation is exercised. The first stimulus is an impulse. Steps at full positive and full negative scale follow. Their overshoot drives the 14-bit outputs past range and checks the wrap arithmetic against an integer model. Random samples are then sent with random input gaps and random output stalls, which fill both stages and exercise the back-pressure and hold rules.

// File: rtl/lp_sos_pkg.sv
package lp_sos_pkg;
  // term word: [5] in use, [4] subtract, [3:0] left shift
  localparam int TERM_W  = 6;
  localparam int SHIFT_W = 4;
  localparam int NCOEF   = 5;   // slot order: b0, b1, b2, a1, a2

  function automatic logic [TERM_W-1:0] t_add(input int s);
    logic [SHIFT_W-1:0] sh;
    sh = SHIFT_W'(s);
    return {2'b10, sh};
  endfunction

  function automatic logic [TERM_W-1:0] t_sub(input int s);
    logic [SHIFT_W-1:0] sh;
    sh = SHIFT_W'(s);
    return {2'b11, sh};
  endfunction

  function automatic logic [TERM_W-1:0] t_nil();
    return '0;
  endfunction

  function automatic bit term_used(input logic [TERM_W-1:0] t);
    return t[TERM_W-1];
  endfunction

  function automatic bit term_neg(input logic [TERM_W-1:0] t);
    return t[TERM_W-2];
  endfunction

  function automatic int term_shift(input logic [TERM_W-1:0] t);
    return int'(t[SHIFT_W-1:0]);
  endfunction
endpackage

// File: rtl/lp_sos_csd_sum.sv
module lp_sos_csd_sum
  import lp_sos_pkg::*;
#(
  parameter int DW = 14,
  parameter int AW = 22,
  parameter int NT = 2,
  parameter logic [NCOEF-1:0][NT-1:0][TERM_W-1:0] TERMS = '0,
  parameter logic [NCOEF-1:0] FB_MASK = 5'b11000
) (
  input  logic [NCOEF-1:0][DW-1:0] ops,
  output logic [AW-1:0]            acc
);
  localparam int NSLOT = NCOEF * NT;
  localparam int EXT   = AW - DW;

  logic [AW-1:0] chain [0:NSLOT];
  assign chain[0] = '0;

  for (genvar c = 0; c < NCOEF; c++) begin : g_coef
    for (genvar t = 0; t < NT; t++) begin : g_slot
      localparam int K = c * NT + t;
      localparam logic [TERM_W-1:0] TV = TERMS[c][t];
      if (term_used(TV)) begin : g_term
        localparam bit SUB = term_neg(TV) ^ FB_MASK[c];
        localparam int SH  = term_shift(TV);
        logic [AW-1:0] part;
        assign part = {{EXT{ops[c][DW-1]}}, ops[c]} << SH;
        if (SUB) begin : g_sub
          assign chain[K+1] = chain[K] - part;
        end else begin : g_add
          assign chain[K+1] = chain[K] + part;
        end
      end else begin : g_skip
        assign chain[K+1] = chain[K];
      end
    end
  end

  assign acc = chain[NSLOT];
endmodule

// File: rtl/lp_sos_stage.sv
module lp_sos_stage
  import lp_sos_pkg::*;
#(
  parameter int DW = 14,
  parameter int AW = 22,
  parameter int NT = 2,
  parameter logic [NCOEF-1:0][NT-1:0][TERM_W-1:0] TERMS = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int FRAC = AW - DW;

  logic [DW-1:0] x1, x2, y2;
  logic [AW-1:0] acc;
  logic          take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  lp_sos_csd_sum #(
    .DW(DW), .AW(AW), .NT(NT), .TERMS(TERMS), .FB_MASK(5'b11000)
  ) u_sum (
    .ops({y2, out_data, x2, x1, in_data}),
    .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x1        <= '0;
      x2        <= '0;
      y2        <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (take) begin
      x1        <= in_data;
      x2        <= x1;
      y2        <= out_data;
      out_data  <= acc[AW-1:FRAC];
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lp_sos_cascade.sv
module lp_sos_cascade
  import lp_sos_pkg::*;
#(
  parameter int DW = 14,
  parameter int AW = 22,
  parameter int NT = 2,
  parameter logic [NCOEF-1:0][NT-1:0][TERM_W-1:0] S1_TERMS = {
    {t_add(5), t_add(7)},   // a2 = 160
    {t_sub(7), t_sub(8)},   // a1 = -384
    {t_nil(),  t_add(3)},   // b2 = 8
    {t_nil(),  t_add(4)},   // b1 = 16
    {t_nil(),  t_add(3)}    // b0 = 8
  },
  parameter logic [NCOEF-1:0][NT-1:0][TERM_W-1:0] S2_TERMS = {
    {t_nil(),  t_add(7)},   // a2 = 128
    {t_sub(6), t_sub(8)},   // a1 = -320
    {t_nil(),  t_add(4)},   // b2 = 16
    {t_nil(),  t_add(5)},   // b1 = 32
    {t_nil(),  t_add(4)}    // b0 = 16
  }
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          s1_valid, s2_ready;
  logic [DW-1:0] s1_data;

  lp_sos_stage #(.DW(DW), .AW(AW), .NT(NT), .TERMS(S1_TERMS)) u_s1 (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(s1_valid), .out_ready(s2_ready), .out_data(s1_data)
  );

  lp_sos_stage #(.DW(DW), .AW(AW), .NT(NT), .TERMS(S2_TERMS)) u_s2 (
    .clk(clk), .rst(rst),
    .in_valid(s1_valid), .in_ready(s2_ready), .in_data(s1_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: rtl/lp_sos_cascade_chk.sv
module lp_sos_cascade_chk #(
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          mid_valid
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  // R1: both stages empty right after reset
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    started && $fell(rst) |-> !out_valid && !mid_valid);

  // R4: an accepted sample reaches the first stage on the next edge
  a_r4_first_hop: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> mid_valid);

  // R4: output only rises after the first stage held a sample
  a_r4_second_hop: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(mid_valid));

  // R5: stalled output holds
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R6: full pipeline under stall refuses input
  a_r6_full_refuses: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && mid_valid |-> !in_ready);
endmodule

bind lp_sos_cascade lp_sos_cascade_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .mid_valid(s1_valid)
);

// File: tb/tb_lp_sos_cascade.sv
module tb_lp_sos_cascade;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [13:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [13:0] out_data;

  int total = 0;
  int bad = 0;
  int n_acc = 0;
  int n_out = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  logic [13:0] expq[$];

  // R10 coefficients, units of 1/256: {b0,b1,b2,a1,a2}
  int cf [2][5] = '{'{8, 16, 8, -384, 160}, '{16, 32, 16, -320, 128}};
  int mx1 [2] = '{0, 0};
  int mx2 [2] = '{0, 0};
  int my1 [2] = '{0, 0};
  int my2 [2] = '{0, 0};

  always #10 clk = ~clk;   // 50 MHz

  lp_sos_cascade dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic int sec_step(input int s, input int x);
    int acc;
    logic [21:0] a22;
    logic signed [13:0] y;
    acc = cf[s][0]*x + cf[s][1]*mx1[s] + cf[s][2]*mx2[s]
        - cf[s][3]*my1[s] - cf[s][4]*my2[s];
    a22 = acc[21:0];          // R9 wrap
    y = a22[21:8];            // R2 slice
    mx2[s] = mx1[s]; mx1[s] = x;
    my2[s] = my1[s]; my1[s] = int'(y);
    return int'(y);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: call at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic signed [13:0] v);
    bit taken = 1'b0;
    in_valid = 1'b1;
    in_data  = v;
    while (!taken) begin
      #2;
      if (in_ready) begin
        int y1;
        y1 = sec_step(0, int'(v));
        expq.push_back(14'(sec_step(1, y1)));   // R3 cascade
        n_acc++;
        taken = 1'b1;
        @(negedge clk);
      end else begin
        in_data = ~v;       // R6: offered while refused, must not enter
        @(negedge clk);
        in_data = v;
      end
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // output back-pressure source
  always @(negedge clk) begin
    if (stall_mode) out_ready <= ($urandom_range(0, 2) != 0);
    else out_ready <= 1'b1;
  end

  // monitor / scoreboard
  bit held = 1'b0;
  logic [13:0] held_val = '0;
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (held) begin
        check(out_valid && out_data == held_val, "R5 hold", int'(out_data), int'(held_val));
      end
      if (out_valid && out_ready) begin
        n_out++;
        if (expq.size() == 0) begin
          check(1'b0, "R8 extra output", int'($signed(out_data)), 0);
        end else begin
          logic [13:0] e;
          e = expq.pop_front();
          check(out_data == e, "R2/R3/R9 data", int'($signed(out_data)), int'($signed(e)));
        end
      end
      held = out_valid && !out_ready;
      held_val = out_data;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_out, n_acc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check(!out_valid, "R1 out_valid in reset", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    #3;
    check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready, "R1 in_ready after reset", int'(in_ready), 1);
    @(negedge clk);

    // R4 latency with free output
    send(14'sd4000);
    in_valid = 1'b0;
    #3;
    check(!out_valid, "R4 not after one edge", int'(out_valid), 0);
    @(negedge clk);
    #3;
    check(out_valid, "R4 valid after two edges", int'(out_valid), 1);
    idle(2);

    // R2 impulse tail
    for (int i = 0; i < 40; i++) send(14'sd0);
    // R7 gaps between samples
    for (int i = 0; i < 20; i++) begin send(14'sd3000); idle(i % 3); end
    // R9 full-scale steps, overshoot wraps
    for (int i = 0; i < 50; i++) send(14'sh1fff);
    for (int i = 0; i < 50; i++) send(-14'sd8192);
    for (int i = 0; i < 30; i++) send(14'sh1fff);
    idle(6);

    // R5, R6, R7 random data with stalls and gaps
    stall_mode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      send(14'($urandom_range(0, 16383)));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(1);
    stall_mode = 1'b0;
    idle(20);

    // R8 one output per accepted sample
    check(expq.size() == 0, "R8 queue drained", expq.size(), 0);
    check(n_out == n_acc, "R8 count match", n_out, n_acc);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule